// File: doc/BRIEF.md
# Clock-Synchronous Serial Transfer Unit

This block is a full-duplex serial shifter that runs its own shift clock. Software sees a small register bus with a shared data location, a status location and a control location. A byte written to the data location is held in a transmit buffer. As soon as the shifter is idle it takes the byte. It then exchanges eight bits with the far side: one bit goes out on the data-out pin and one bit comes in on the data-in pin for each shift-clock period. The rate comes from an external baud tick, and each tick is one half period of the shift clock.

An exchange starts only through a write to the data location. To collect a byte from the far side without sending anything, software therefore writes a dummy byte. When eight bits have been shifted, the received byte lands in the receive register and the ready flag rises. If the previous byte has not yet been read at that moment, the new byte is dropped and the overrun flag reports it. Overrun is the only error this unit detects. The parity and framing positions of the status byte exist and always read 0. There is one receive interrupt output and one transmit interrupt output, and each has its own enable.

Top module: `sync_serial_xfer`

## Requirements
- R1: After reset the status byte reads 0x02 (only transmit-empty set), the shift clock and data out are high, and both interrupts are low.
- R2: An exchange starts only after a write to address 0. With no such write, baud ticks leave the shift clock high and busy (status bit 5) at 0.
- R3: The shift clock idles high and toggles on each baud tick during an exchange. Data out changes on falling edges, data in is sampled on rising edges, LSB first, with exactly 8 rising edges per exchange.
- R4: On the edge after the 16th tick, busy drops. One edge later the received byte is in the receive register and ready (status bit 0) reads 1.
- R5: A read strobe at address 0 returns the receive register in the same cycle and clears ready on that edge.
- R6: Transmit-empty (status bit 1) clears on the edge of a write to address 0. It sets on the next edge at which the shifter takes the byte. A byte written while busy waits and starts when the running exchange ends.
- R7: If an exchange completes while ready is 1 and no read happens in that cycle, overrun (status bit 2) sets and the receive register keeps its old byte. Writing address 2 with bit 7 set clears overrun.
- R8: The parity error (status bit 3) and framing error (status bit 4) positions always read 0.
- R9: irq_rx_o = rx enable (control bit 0) AND (ready OR overrun). irq_tx_o = tx enable (control bit 1) AND transmit-empty. Both enables are written at address 2 and are readable there.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 2 | Register address: 0 data, 1 status, 2 control |
| bus_wdata | input | 8 | Write data |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (side effect at address 0) |
| bus_rdata | output | 8 | Read data for the current address |
| baud_tick | input | 1 | One-cycle pulse, one half shift-clock period |
| sck_o | output | 1 | Shift clock, idles high |
| sdi_i | input | 1 | Serial data in |
| sdo_o | output | 1 | Serial data out |
| irq_rx_o | output | 1 | Receive interrupt |
| irq_tx_o | output | 1 | Transmit interrupt |

## Verification
Transmit-empty is due 1 edge after a write edge, and 2 edges after it when the shifter is idle and takes the byte. Busy and the shift clock move on the tick edge itself. Ready, overrun and the receive interrupt follow 1 edge after the 16th tick edge. The bench drives inputs on falling clock edges and generates every tick itself, so it knows which rising edge each result belongs to. It checks the value just before that edge and again just after it, at the next falling edge.

// File: rtl/ssx_pkg.sv
package ssx_pkg;
  localparam int ADDR_DATA = 0;
  localparam int ADDR_STAT = 1;
  localparam int ADDR_CTRL = 2;

  localparam int ST_RDY  = 0;
  localparam int ST_TXE  = 1;
  localparam int ST_OVR  = 2;
  localparam int ST_PAR  = 3;
  localparam int ST_FRM  = 4;
  localparam int ST_BUSY = 5;

  localparam int CT_RXIE = 0;
  localparam int CT_TXIE = 1;
  localparam int CT_CLR  = 7;
endpackage

// File: rtl/ssx_rst_sync.sv
module ssx_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = sync_q[STAGES-1];
endmodule

// File: rtl/ssx_shifter.sv
module ssx_shifter #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic              tx_full_i,
  input  logic [DATA_W-1:0] tx_data_i,
  input  logic              sdi_i,
  output logic              load_o,
  output logic              busy_o,
  output logic              done_o,
  output logic [DATA_W-1:0] rx_byte_o,
  output logic              sck_o,
  output logic              sdo_o
);
  localparam int HW = $clog2(2 * DATA_W);
  localparam logic [HW-1:0] LAST_HALF = HW'(2 * DATA_W - 1);

  logic              busy_q, busy_n;
  logic [HW-1:0]     half_q, half_n;
  logic              sck_q, sck_n;
  logic              sdo_q, sdo_n;
  logic              done_q, done_n;
  logic [DATA_W-1:0] tx_sh_q, tx_sh_n;
  logic [DATA_W-1:0] rx_sh_q, rx_sh_n;

  assign load_o = !busy_q && tx_full_i;

  always_comb begin
    busy_n  = busy_q;
    half_n  = half_q;
    sck_n   = sck_q;
    sdo_n   = sdo_q;
    done_n  = 1'b0;
    tx_sh_n = tx_sh_q;
    rx_sh_n = rx_sh_q;
    if (load_o) begin
      busy_n  = 1'b1;
      half_n  = '0;
      sck_n   = 1'b1;
      tx_sh_n = tx_data_i;
    end else if (busy_q && tick_i) begin
      half_n = half_q + 1'b1;
      if (!half_q[0]) begin
        sck_n   = 1'b0;
        sdo_n   = tx_sh_q[0];
        tx_sh_n = tx_sh_q >> 1;
      end else begin
        sck_n   = 1'b1;
        rx_sh_n = {sdi_i, rx_sh_q[DATA_W-1:1]};
        if (half_q == LAST_HALF) begin
          busy_n = 1'b0;
          done_n = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      half_q  <= '0;
      sck_q   <= 1'b1;
      sdo_q   <= 1'b1;
      done_q  <= 1'b0;
      tx_sh_q <= '0;
      rx_sh_q <= '0;
    end else begin
      busy_q  <= busy_n;
      half_q  <= half_n;
      sck_q   <= sck_n;
      sdo_q   <= sdo_n;
      done_q  <= done_n;
      tx_sh_q <= tx_sh_n;
      rx_sh_q <= rx_sh_n;
    end
  end

  assign busy_o    = busy_q;
  assign done_o    = done_q;
  assign rx_byte_o = rx_sh_q;
  assign sck_o     = sck_q;
  assign sdo_o     = sdo_q;

  p_idle_clk_high_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_q |-> sck_q);
  p_start_needs_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_q) |-> $past(tx_full_i));
  p_done_on_rise_r4: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> (sck_q && $past(busy_q)));
endmodule

// File: rtl/ssx_irq.sv
module ssx_irq #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] src_i,
  input  logic         en_i,
  output logic         irq_o
);
  logic [N-1:0] gated;

  for (genvar i = 0; i < N; i++) begin : g_src
    assign gated[i] = src_i[i] & en_i;
  end

  assign irq_o = |gated;

  p_irq_needs_enable_r9: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> en_i);
endmodule

// File: rtl/ssx_regs.sv
module ssx_regs
  import ssx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_wr,
  input  logic              bus_rd,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              load_i,
  input  logic              done_i,
  input  logic              busy_i,
  input  logic [DATA_W-1:0] rx_byte_i,
  output logic              tx_full_o,
  output logic [DATA_W-1:0] tx_data_o,
  output logic              rx_rdy_o,
  output logic              ovr_o,
  output logic              rx_ie_o,
  output logic              tx_ie_o
);
  logic              tx_full_q, tx_full_n;
  logic [DATA_W-1:0] tx_data_q, tx_data_n;
  logic              rx_rdy_q, rx_rdy_n;
  logic [DATA_W-1:0] rx_data_q, rx_data_n;
  logic              ovr_q, ovr_n;
  logic              rx_ie_q, rx_ie_n;
  logic              tx_ie_q, tx_ie_n;

  logic wr_data, rd_data, wr_ctrl;
  assign wr_data = bus_wr && (bus_addr == ADDR_W'(ADDR_DATA));
  assign rd_data = bus_rd && (bus_addr == ADDR_W'(ADDR_DATA));
  assign wr_ctrl = bus_wr && (bus_addr == ADDR_W'(ADDR_CTRL));

  always_comb begin
    tx_full_n = tx_full_q;
    tx_data_n = tx_data_q;
    rx_rdy_n  = rx_rdy_q;
    rx_data_n = rx_data_q;
    ovr_n     = ovr_q;
    rx_ie_n   = rx_ie_q;
    tx_ie_n   = tx_ie_q;

    if (wr_data) begin
      tx_full_n = 1'b1;
      tx_data_n = bus_wdata;
    end else if (load_i) begin
      tx_full_n = 1'b0;
    end

    if (done_i) begin
      if (rx_rdy_q && !rd_data) begin
        ovr_n = 1'b1;
      end else begin
        rx_data_n = rx_byte_i;
      end
      rx_rdy_n = 1'b1;
    end else if (rd_data) begin
      rx_rdy_n = 1'b0;
    end

    if (wr_ctrl) begin
      rx_ie_n = bus_wdata[CT_RXIE];
      tx_ie_n = bus_wdata[CT_TXIE];
      if (bus_wdata[CT_CLR] && !(done_i && rx_rdy_q && !rd_data)) ovr_n = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_full_q <= 1'b0;
      tx_data_q <= '0;
      rx_rdy_q  <= 1'b0;
      rx_data_q <= '0;
      ovr_q     <= 1'b0;
      rx_ie_q   <= 1'b0;
      tx_ie_q   <= 1'b0;
    end else begin
      tx_full_q <= tx_full_n;
      tx_data_q <= tx_data_n;
      rx_rdy_q  <= rx_rdy_n;
      rx_data_q <= rx_data_n;
      ovr_q     <= ovr_n;
      rx_ie_q   <= rx_ie_n;
      tx_ie_q   <= tx_ie_n;
    end
  end

  logic [DATA_W-1:0] status, ctrl_rd;
  always_comb begin
    status          = '0;
    status[ST_RDY]  = rx_rdy_q;
    status[ST_TXE]  = !tx_full_q;
    status[ST_OVR]  = ovr_q;
    status[ST_PAR]  = 1'b0;
    status[ST_FRM]  = 1'b0;
    status[ST_BUSY] = busy_i;
    ctrl_rd          = '0;
    ctrl_rd[CT_RXIE] = rx_ie_q;
    ctrl_rd[CT_TXIE] = tx_ie_q;
  end

  always_comb begin
    case (bus_addr)
      ADDR_W'(ADDR_DATA): bus_rdata = rx_data_q;
      ADDR_W'(ADDR_STAT): bus_rdata = status;
      ADDR_W'(ADDR_CTRL): bus_rdata = ctrl_rd;
      default:            bus_rdata = '0;
    endcase
  end

  assign tx_full_o = tx_full_q;
  assign tx_data_o = tx_data_q;
  assign rx_rdy_o  = rx_rdy_q;
  assign ovr_o     = ovr_q;
  assign rx_ie_o   = rx_ie_q;
  assign tx_ie_o   = tx_ie_q;

  p_ready_after_done_r4: assert property (@(posedge clk) disable iff (!rst_n)
    done_i |=> rx_rdy_q);
  p_overrun_keeps_byte_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (done_i && rx_rdy_q && !rd_data) |=> (ovr_q && $stable(rx_data_q)));
  p_write_fills_tx_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_data |=> tx_full_q);
  p_read_clears_ready_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data && !done_i) |=> !rx_rdy_q);
endmodule

// File: rtl/sync_serial_xfer.sv
module sync_serial_xfer #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_wr,
  input  logic              bus_rd,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              baud_tick,
  output logic              sck_o,
  input  logic              sdi_i,
  output logic              sdo_o,
  output logic              irq_rx_o,
  output logic              irq_tx_o
);
  logic              rst_n_s;
  logic              load, busy, done, tx_full, rx_rdy, ovr, rx_ie, tx_ie;
  logic [DATA_W-1:0] tx_data, rx_byte;

  ssx_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_s)
  );

  ssx_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n_s),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_rdata(bus_rdata),
    .load_i(load), .done_i(done), .busy_i(busy), .rx_byte_i(rx_byte),
    .tx_full_o(tx_full), .tx_data_o(tx_data), .rx_rdy_o(rx_rdy), .ovr_o(ovr),
    .rx_ie_o(rx_ie), .tx_ie_o(tx_ie)
  );

  ssx_shifter #(.DATA_W(DATA_W)) u_shift (
    .clk(clk), .rst_n(rst_n_s), .tick_i(baud_tick),
    .tx_full_i(tx_full), .tx_data_i(tx_data), .sdi_i(sdi_i),
    .load_o(load), .busy_o(busy), .done_o(done), .rx_byte_o(rx_byte),
    .sck_o(sck_o), .sdo_o(sdo_o)
  );

  ssx_irq #(.N(2)) u_irq_rx (
    .clk(clk), .rst_n(rst_n_s), .src_i({ovr, rx_rdy}), .en_i(rx_ie), .irq_o(irq_rx_o)
  );

  ssx_irq #(.N(1)) u_irq_tx (
    .clk(clk), .rst_n(rst_n_s), .src_i(!tx_full), .en_i(tx_ie), .irq_o(irq_tx_o)
  );

  p_tx_irq_means_empty_r9: assert property (@(posedge clk) disable iff (!rst_n_s)
    irq_tx_o |-> !tx_full);
endmodule

// File: tb/sync_serial_xfer_tb.sv
module sync_serial_xfer_tb;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [1:0] bus_addr;
  logic [7:0] bus_wdata;
  logic       bus_wr, bus_rd, baud_tick, sdi_i;
  logic [7:0] bus_rdata;
  logic       sck_o, sdo_o, irq_rx_o, irq_tx_o;

  int n_chk = 0;
  int n_err = 0;

  logic [7:0] slave_byte;
  int         sbit;
  logic [7:0] cap;
  int         rises;
  logic       cap_on = 1'b0;

  always #10 clk = ~clk;

  sync_serial_xfer u_dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata), .baud_tick(baud_tick),
    .sck_o(sck_o), .sdi_i(sdi_i), .sdo_o(sdo_o), .irq_rx_o(irq_rx_o), .irq_tx_o(irq_tx_o)
  );

  always @(negedge sck_o) if (cap_on) begin
    sdi_i <= slave_byte[sbit[2:0]];
    sbit  <= sbit + 1;
  end

  always @(posedge sck_o) if (cap_on) begin
    cap   <= {sdo_o, cap[7:1]};
    rises <= rises + 1;
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] status_now();
    return bus_rdata;
  endfunction

  task automatic peek_status(output logic [7:0] st);
    bus_addr = 2'd1;
    #1 st = bus_rdata;
  endtask

  task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; bus_addr = 2'd1;
  endtask

  task automatic tick_n(input int n);
    for (int i = 0; i < n; i++) begin
      repeat (2) @(negedge clk);
      baud_tick = 1'b1;
      @(negedge clk);
      baud_tick = 1'b0;
    end
  endtask

  task automatic arm_slave(input logic [7:0] b);
    slave_byte = b; sbit = 0; cap = '0; rises = 0; cap_on = 1'b1;
  endtask

  task automatic t_reset();
    logic [7:0] st;
    peek_status(st);
    check("R1 status", st, 8'h02);
    check("R1 sck", sck_o, 1'b1);
    check("R1 sdo", sdo_o, 1'b1);
    check("R1 irqs", {irq_rx_o, irq_tx_o}, 2'b00);
  endtask

  task automatic t_no_start();
    logic [7:0] st;
    tick_n(4);
    peek_status(st);
    check("R2 sck idle without write", sck_o, 1'b1);
    check("R2 busy without write", st[5], 1'b0);
  endtask

  task automatic t_exchange(input logic [7:0] tx, input logic [7:0] rx);
    logic [7:0] st;
    arm_slave(rx);
    bus_write(2'd0, tx);
    peek_status(st);
    check("R6 empty clears on write", st[1], 1'b0);
    @(negedge clk);
    peek_status(st);
    check("R6 empty sets on take", st[1], 1'b1);
    check("R2 busy after write", st[5], 1'b1);
    tick_n(1);
    check("R3 sck falls on first tick", sck_o, 1'b0);
    check("R3 first bit out", sdo_o, tx[0]);
    tick_n(15);
    peek_status(st);
    check("R4 busy drops on last tick", st[5], 1'b0);
    check("R4 ready not yet", st[0], 1'b0);
    @(negedge clk);
    peek_status(st);
    check("R4 ready set", st[0], 1'b1);
    check("R3 sent byte lsb first", cap, tx);
    check("R3 eight rising edges", rises, 8);
    check("R3 sck back high", sck_o, 1'b1);
    bus_addr = 2'd0; bus_rd = 1'b1;
    #1 check("R5 read byte", bus_rdata, rx);
    @(negedge clk);
    bus_rd = 1'b0;
    peek_status(st);
    check("R5 ready cleared by read", st[0], 1'b0);
    cap_on = 1'b0;
  endtask

  task automatic t_queue_overrun();
    logic [7:0] st;
    arm_slave(8'h3C);
    bus_write(2'd0, 8'hA1);
    @(negedge clk);
    bus_write(2'd0, 8'h5E);
    peek_status(st);
    check("R6 queued byte waits", {st[5], st[1]}, 2'b10);
    tick_n(16);
    @(negedge clk);
    peek_status(st);
    check("R6 queued byte starts", {st[5], st[1], st[0]}, 3'b111);
    check("R3 first byte sent", cap, 8'hA1);
    arm_slave(8'hC5);
    tick_n(16);
    @(negedge clk);
    peek_status(st);
    check("R7 overrun set", st[2], 1'b1);
    check("R8 parity and framing zero", st[4:3], 2'b00);
    check("R3 queued byte sent", cap, 8'h5E);
    bus_addr = 2'd0; bus_rd = 1'b1;
    #1 check("R7 old byte kept", bus_rdata, 8'h3C);
    @(negedge clk);
    bus_rd = 1'b0;
    bus_write(2'd2, 8'h80);
    peek_status(st);
    check("R7 overrun cleared", st[2], 1'b0);
    cap_on = 1'b0;
  endtask

  task automatic t_irq();
    logic [7:0] st;
    bus_write(2'd2, 8'h03);
    bus_addr = 2'd2;
    #1 check("R9 enables readable", bus_rdata, 8'h03);
    check("R9 tx irq when empty", irq_tx_o, 1'b1);
    check("R9 rx irq idle", irq_rx_o, 1'b0);
    arm_slave(8'h96);
    bus_write(2'd0, 8'h00);
    check("R9 tx irq drops while full", irq_tx_o, 1'b0);
    @(negedge clk);
    tick_n(16);
    check("R9 rx irq before ready", irq_rx_o, 1'b0);
    @(negedge clk);
    check("R9 rx irq on ready", irq_rx_o, 1'b1);
    bus_write(2'd2, 8'h00);
    check("R9 irqs masked", {irq_rx_o, irq_tx_o}, 2'b00);
    peek_status(st);
    check("R8 parity and framing zero after dummy", st[4:3], 2'b00);
    cap_on = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    rst_n = 1'b0; bus_addr = 2'd1; bus_wdata = '0; bus_wr = 1'b0; bus_rd = 1'b0;
    baud_tick = 1'b0; sdi_i = 1'b0; slave_byte = '0; sbit = 0; cap = '0; rises = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_no_start();
    t_exchange(8'hB2, 8'h4D);
    t_exchange(8'h01, 8'hFE);
    t_queue_overrun();
    t_irq();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule